// File: doc/BRIEF.md
# Interrupt and Halt Response Controller

This block decides, at each instruction boundary of an 8-bit processor core, whether the core keeps running, sits halted, or services a maskable or non-maskable interrupt. It holds the two interrupt enable flip-flops and the interrupt mode. From the current service state it drives the enables that replace the fetched opcode at the instruction-load step. It also holds the program counter still, produces the non-maskable vector constant, masks the restart vector field, and steers the restart sequence through one extra memory read in vectored mode.

The sequencer feeds it strobes at fixed points: `ld_stb` at the instruction-load step, `vec_stb` where the restart vector is formed, `seq_pt` at the sequencing point that ends the first machine cycle of the restart, and `insn_end` at the instruction boundary. `insn_end` comes with the opcode of the instruction that is finishing. The decoder pulses `di_ei_we`, `im_we` and `retn_we` for the matching instructions. It pulses `svc_done` when the restart sequence has pushed the return address, which sends the block back to normal running.

Top module: `irq_resp_ctl`

## Requirements
- R1: In the halted state, `bus_zero_oe` is 1 during `ld_stb`, so a 0x00 opcode is loaded. Halt is entered from running on `halt_cmd`.
- R2: In the maskable service state with mode 1 or mode 2, `bus_ff_oe` is 1 during `ld_stb`, so a 0xFF opcode is loaded. In mode 1, `bus_ff_oe` is also 1 during `vec_stb`. In mode 0, neither strobe forces anything.
- R3: `pc_inc_en` is 0 while halted or in either service state, and 1 while running.
- R4: In the non-maskable service state, during `vec_stb`, `vec_nmi_oe` is 1 and `opc_path_en` is 0. During `ld_stb`, `bus_ff_oe` is 1.
- R5: Entering the non-maskable service state clears IFF1 and keeps IFF2. Entering the maskable service state clears both.
- R6: `di_ei_we` writes opcode bit 3 into both IFF1 and IFF2. `retn_we` copies IFF2 into IFF1.
- R7: `im_we` loads opcode bits [4:3] into `im_mode`. Code 2'b10 selects mode 1, 2'b11 selects mode 2, and 2'b00 or 2'b01 selects mode 0.
- R8: At `seq_pt`, a mode 2 maskable service gives `seq_mread`=1 and `seq_set_m1`=0, which adds one memory read. Any other state gives `seq_mread`=0 and `seq_set_m1`=1.
- R9: `mask543_en` is 0 in the non-maskable service state and in mode 2 maskable service, and 1 otherwise.
- R10: No interrupt is accepted at an `insn_end` whose opcode is 0xF3, 0xFB, 0xCB, 0xED, 0xDD or 0xFD.
- R11: Acceptance happens only at an `insn_end`, and only from running or halted. A pending non-maskable request wins over `irq`. A non-maskable request is latched on a rising edge of `nmi`, so holding `nmi` high gives one service. `irq` is accepted only when IFF1 is 1.
- R12: After reset, the state is running, IFF1, IFF2 and `im_mode` are 0, and no request is pending. `svc_done` returns either service state to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi | input | 1 | Non-maskable request line, edge sensitive |
| irq | input | 1 | Maskable request line, level sensitive |
| halt_cmd | input | 1 | Halt instruction is executing |
| insn_end | input | 1 | Instruction boundary; acceptance point |
| opcode | input | OPC_W | Opcode of the current or finishing instruction |
| ld_stb | input | 1 | Instruction-load step |
| vec_stb | input | 1 | Restart vector formation step |
| seq_pt | input | 1 | Sequencing point of the restart's first cycle |
| di_ei_we | input | 1 | DI/EI strobe |
| im_we | input | 1 | Mode-set strobe |
| retn_we | input | 1 | Return-from-NMI strobe |
| svc_done | input | 1 | Restart sequence finished |
| bus_zero_oe | output | 1 | Force 0x00 onto the internal bus |
| bus_ff_oe | output | 1 | Force 0xFF onto the internal bus |
| opc_path_en | output | 1 | Opcode path to the vector bus enabled |
| vec_nmi_oe | output | 1 | Drive the non-maskable vector constant |
| vec_nmi | output | OPC_W | Non-maskable vector value (0x66) |
| mask543_en | output | 1 | Pass opcode bits [5:3] into the restart vector |
| pc_inc_en | output | 1 | Program counter increment allowed |
| seq_mread | output | 1 | Insert a memory read cycle next |
| seq_set_m1 | output | 1 | Return to the fetch cycle next |
| iff1 | output | 1 | Interrupt enable flip-flop 1 |
| iff2 | output | 1 | Interrupt enable flip-flop 2 |
| im_mode | output | 2 | Stored mode code |
| in_halt | output | 1 | Halted state |
| in_intr | output | 1 | Maskable service state |
| in_nmi | output | 1 | Non-maskable service state |

## Verification
The assertions assume a sequencer that pulses `svc_done` only inside a service state. They also assume that the DI/EI and return strobes never coincide with an accepting `insn_end`, and that `insn_end` always carries the opcode that just finished. The stimulus keeps to this. Each mode and decoder strobe is raised in a cycle of its own, and `svc_done` is sent only after a service has been observed. Acceptance is tried with inhibiting and non-inhibiting opcodes, with IFF1 both cleared and set, and with both requests present at once.

// File: rtl/irq_resp_pkg.sv
// Shared types and constants for the interrupt and halt response controller.
// Assumes an 8-bit opcode space.
package irq_resp_pkg;

    // Service state of the core; the four states are mutually exclusive.
    typedef enum logic [1:0] {
        SVC_RUN  = 2'd0,
        SVC_HALT = 2'd1,
        SVC_MINT = 2'd2,
        SVC_NMI  = 2'd3
    } svc_state_e;

    // Mode codes as loaded from opcode bits [4:3].
    localparam logic [1:0] MODE_CODE_1 = 2'b10;
    localparam logic [1:0] MODE_CODE_2 = 2'b11;

    // Opcodes after which no interrupt may be taken.
    localparam int          NUM_INHIBIT = 6;
    localparam logic [7:0]  INHIBIT_OPC [NUM_INHIBIT] =
        '{8'hF3, 8'hFB, 8'hCB, 8'hED, 8'hDD, 8'hFD};

endpackage

// File: rtl/irq_enable_regs.sv
// Interrupt enable flip-flops and stored interrupt mode.
// Service entry has priority over the DI/EI and return strobes. The decoder
// never raises two strobes in one cycle.
module irq_enable_regs #(
    parameter int OPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_nmi,
    input  logic             enter_intr,
    input  logic             di_ei_we,
    input  logic             im_we,
    input  logic             retn_we,
    input  logic [OPC_W-1:0] opcode,
    output logic             iff1,
    output logic             iff2,
    output logic [1:0]       im_mode
);
    localparam int EN_BIT = 3;
    localparam int IM_LO  = 3;

    // Update the enable flip-flops: service entry, then DI/EI, then return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (enter_nmi) begin
            iff1 <= 1'b0;
        end else if (enter_intr) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (di_ei_we) begin
            iff1 <= opcode[EN_BIT];
            iff2 <= opcode[EN_BIT];
        end else if (retn_we) begin
            iff1 <= iff2;
        end
    end

    // Load the mode code from the opcode on the mode-set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      im_mode <= 2'b00;
        else if (im_we)  im_mode <= opcode[IM_LO+1:IM_LO];
    end

    AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (!rst_n)
        enter_nmi |=> (!iff1 && iff2 == $past(iff2)));  // R5
    AST_INTR_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_intr && !enter_nmi) |=> (!iff1 && !iff2));  // R5
    AST_RETN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (retn_we && !enter_nmi && !enter_intr && !di_ei_we) |=> (iff1 == $past(iff2)));  // R6
    AST_DIEI_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (di_ei_we && !enter_nmi && !enter_intr) |=> (iff1 == iff2));  // R6

endmodule

// File: rtl/irq_service_fsm.sv
// Service-state sequencer. It latches a non-maskable request on a rising edge,
// decides acceptance at instruction boundaries, and tracks halt and service.
// Assumes svc_done arrives only during a service state.
module irq_service_fsm
    import irq_resp_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi,
    input  logic             irq,
    input  logic             halt_cmd,
    input  logic             insn_end,
    input  logic [OPC_W-1:0] opcode,
    input  logic             svc_done,
    input  logic             iff1,
    output svc_state_e       state,
    output logic             enter_nmi,
    output logic             enter_intr
);
    logic       nmi_q;
    logic       nmi_pend;
    logic       inhibit;
    logic       accept_ok;
    logic       can_take;
    svc_state_e state_nx;

    // Compare the finishing opcode against the inhibit list.
    always_comb begin
        inhibit = 1'b0;
        for (int i = 0; i < NUM_INHIBIT; i++) begin
            if (opcode == OPC_W'(INHIBIT_OPC[i])) inhibit = 1'b1;
        end
    end

    // Decide which service, if any, starts at this boundary.
    always_comb begin
        accept_ok  = insn_end && !inhibit;
        can_take   = (state == SVC_RUN) || (state == SVC_HALT);
        enter_nmi  = accept_ok && can_take && nmi_pend;
        enter_intr = accept_ok && can_take && !nmi_pend && irq && iff1;
    end

    // Next service state: finish, then NMI, then maskable, then halt.
    always_comb begin
        state_nx = state;
        if (svc_done && (state == SVC_MINT || state == SVC_NMI)) state_nx = SVC_RUN;
        else if (enter_nmi)                                      state_nx = SVC_NMI;
        else if (enter_intr)                                     state_nx = SVC_MINT;
        else if (halt_cmd && state == SVC_RUN)                   state_nx = SVC_HALT;
    end

    // Hold the service state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SVC_RUN;
        else        state <= state_nx;
    end

    // Latch a non-maskable request on its rising edge; clear it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi;
            nmi_pend <= (nmi_pend && !enter_nmi) || (nmi && !nmi_q);
        end
    end

    AST_INTR_NEEDS_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SVC_MINT) ##1 (state == SVC_MINT) |-> $past(iff1));  // R11
    AST_NO_ACCEPT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && inhibit) |=> !(state inside {SVC_MINT, SVC_NMI}) || $past(state inside {SVC_MINT, SVC_NMI}));  // R10
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_nmi && irq && iff1) |=> (state == SVC_NMI));  // R11
    AST_DONE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && (state == SVC_MINT || state == SVC_NMI)) |=> (state == SVC_RUN));  // R12

endmodule

// File: rtl/irq_force_mux.sv
// Converts the service state and mode into the bus forcing, vector,
// program counter and sequencing controls. Purely combinational.
// Assumes the strobes come from the core sequencer at fixed points.
module irq_force_mux
    import irq_resp_pkg::*;
#(
    parameter int         OPC_W   = 8,
    parameter logic [7:0] NMI_VEC = 8'h66
) (
    input  svc_state_e       state,
    input  logic [1:0]       im_mode,
    input  logic             ld_stb,
    input  logic             vec_stb,
    input  logic             seq_pt,
    output logic             bus_zero_oe,
    output logic             bus_ff_oe,
    output logic             opc_path_en,
    output logic             vec_nmi_oe,
    output logic [OPC_W-1:0] vec_nmi,
    output logic             mask543_en,
    output logic             pc_inc_en,
    output logic             seq_mread,
    output logic             seq_set_m1
);
    logic is_halt;
    logic is_mint;
    logic is_nmi;
    logic mode1;
    logic mode2;
    logic vect_int;

    // Decode the state and mode.
    always_comb begin
        is_halt  = (state == SVC_HALT);
        is_mint  = (state == SVC_MINT);
        is_nmi   = (state == SVC_NMI);
        mode1    = (im_mode == MODE_CODE_1);
        mode2    = (im_mode == MODE_CODE_2);
        vect_int = is_mint && mode2;
    end

    // Drive the opcode-forcing and vector controls.
    always_comb begin
        bus_zero_oe = ld_stb && is_halt;
        bus_ff_oe   = (ld_stb && ((is_mint && (mode1 || mode2)) || is_nmi))
                   || (vec_stb && is_mint && mode1);
        vec_nmi_oe  = vec_stb && is_nmi;
        opc_path_en = !(vec_stb && is_nmi);
        vec_nmi     = OPC_W'(NMI_VEC);
        mask543_en  = !(vect_int || is_nmi);
        pc_inc_en   = !(is_halt || is_mint || is_nmi);
        seq_mread   = seq_pt && vect_int;
        seq_set_m1  = seq_pt && !vect_int;
    end

endmodule

// File: rtl/irq_resp_ctl.sv
// Interrupt and halt response controller, top level.
// Links the enable registers, the service sequencer and the forcing logic.
// Assumes the strobe timing described for each input port.
module irq_resp_ctl
    import irq_resp_pkg::*;
#(
    parameter int         OPC_W   = 8,
    parameter logic [7:0] NMI_VEC = 8'h66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi,
    input  logic             irq,
    input  logic             halt_cmd,
    input  logic             insn_end,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ld_stb,
    input  logic             vec_stb,
    input  logic             seq_pt,
    input  logic             di_ei_we,
    input  logic             im_we,
    input  logic             retn_we,
    input  logic             svc_done,
    output logic             bus_zero_oe,
    output logic             bus_ff_oe,
    output logic             opc_path_en,
    output logic             vec_nmi_oe,
    output logic [OPC_W-1:0] vec_nmi,
    output logic             mask543_en,
    output logic             pc_inc_en,
    output logic             seq_mread,
    output logic             seq_set_m1,
    output logic             iff1,
    output logic             iff2,
    output logic [1:0]       im_mode,
    output logic             in_halt,
    output logic             in_intr,
    output logic             in_nmi
);
    svc_state_e state;
    logic       enter_nmi;
    logic       enter_intr;

    irq_enable_regs #(.OPC_W(OPC_W)) u_en (
        .clk(clk), .rst_n(rst_n),
        .enter_nmi(enter_nmi), .enter_intr(enter_intr),
        .di_ei_we(di_ei_we), .im_we(im_we), .retn_we(retn_we),
        .opcode(opcode),
        .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
    );

    irq_service_fsm #(.OPC_W(OPC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .nmi(nmi), .irq(irq), .halt_cmd(halt_cmd), .insn_end(insn_end),
        .opcode(opcode), .svc_done(svc_done), .iff1(iff1),
        .state(state), .enter_nmi(enter_nmi), .enter_intr(enter_intr)
    );

    irq_force_mux #(.OPC_W(OPC_W), .NMI_VEC(NMI_VEC)) u_mux (
        .state(state), .im_mode(im_mode),
        .ld_stb(ld_stb), .vec_stb(vec_stb), .seq_pt(seq_pt),
        .bus_zero_oe(bus_zero_oe), .bus_ff_oe(bus_ff_oe),
        .opc_path_en(opc_path_en), .vec_nmi_oe(vec_nmi_oe), .vec_nmi(vec_nmi),
        .mask543_en(mask543_en), .pc_inc_en(pc_inc_en),
        .seq_mread(seq_mread), .seq_set_m1(seq_set_m1)
    );

    // Bring the state out as three flags.
    always_comb begin
        in_halt = (state == SVC_HALT);
        in_intr = (state == SVC_MINT);
        in_nmi  = (state == SVC_NMI);
    end

    AST_ZERO_FF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_zero_oe && bus_ff_oe));  // R1
    AST_PC_HELD_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_intr || in_nmi) |-> !pc_inc_en);  // R3
    AST_VEC_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        vec_nmi_oe |-> !opc_path_en);  // R4
    AST_SEQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_mread && seq_set_m1));  // R8

endmodule

// File: tb/irq_resp_ctl_test.sv
`timescale 1ns/1ps
module irq_resp_ctl_test;
    localparam int OPC_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct packed {
        logic nmi, irq, halt_cmd, insn_end, ld, vec, seqpt, di_ei, im, retn, done;
        logic [7:0] op;
    } stim_t;

    typedef struct {
        string       req;
        logic [16:0] exp;
    } item_t;

    stim_t s_cur;
    logic  bus_zero_oe, bus_ff_oe, opc_path_en, vec_nmi_oe, mask543_en, pc_inc_en;
    logic  seq_mread, seq_set_m1, iff1, iff2, in_halt, in_intr, in_nmi;
    logic [1:0]       im_mode;
    logic [OPC_W-1:0] vec_nmi;

    irq_resp_ctl #(.OPC_W(OPC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .nmi(s_cur.nmi), .irq(s_cur.irq), .halt_cmd(s_cur.halt_cmd),
        .insn_end(s_cur.insn_end), .opcode(s_cur.op),
        .ld_stb(s_cur.ld), .vec_stb(s_cur.vec), .seq_pt(s_cur.seqpt),
        .di_ei_we(s_cur.di_ei), .im_we(s_cur.im), .retn_we(s_cur.retn),
        .svc_done(s_cur.done),
        .bus_zero_oe(bus_zero_oe), .bus_ff_oe(bus_ff_oe),
        .opc_path_en(opc_path_en), .vec_nmi_oe(vec_nmi_oe), .vec_nmi(vec_nmi),
        .mask543_en(mask543_en), .pc_inc_en(pc_inc_en),
        .seq_mread(seq_mread), .seq_set_m1(seq_set_m1),
        .iff1(iff1), .iff2(iff2), .im_mode(im_mode),
        .in_halt(in_halt), .in_intr(in_intr), .in_nmi(in_nmi)
    );

    // Reference model state (0 run, 1 halt, 2 maskable, 3 nmi)
    int         m_st;
    logic       m_iff1, m_iff2, m_pend, m_nmi_q;
    logic [1:0] m_im;
    item_t      sb[$];
    int         n_run = 0, n_fail = 0;
    bit         finished = 0;

    function automatic stim_t nop();
        stim_t s = '0;
        return s;
    endfunction

    function automatic logic [16:0] expect_vec(stim_t s);
        logic m1 = (m_im == 2'b10);
        logic m2 = (m_im == 2'b11);
        logic mi = (m_st == 2);
        logic mn = (m_st == 3);
        logic [16:0] v;
        v[0]  = s.ld && (m_st == 1);
        v[1]  = (s.ld && ((mi && (m1 || m2)) || mn)) || (s.vec && mi && m1);
        v[2]  = !(s.vec && mn);
        v[3]  = s.vec && mn;
        v[4]  = !((mi && m2) || mn);
        v[5]  = (m_st == 0);
        v[6]  = s.seqpt && mi && m2;
        v[7]  = s.seqpt && !(mi && m2);
        v[8]  = m_iff1;
        v[9]  = m_iff2;
        v[11:10] = m_im;
        v[12] = (m_st == 1);
        v[13] = mi;
        v[14] = mn;
        v[16:15] = 2'b00;
        return v;
    endfunction

    function automatic logic [16:0] observe();
        logic [16:0] v;
        v = {2'b00, in_nmi, in_intr, in_halt, im_mode, iff2, iff1, seq_set_m1, seq_mread,
             pc_inc_en, mask543_en, vec_nmi_oe, opc_path_en, bus_ff_oe, bus_zero_oe};
        return v;
    endfunction

    // Advance the model across one clock edge under stimulus s.
    task automatic model_step(stim_t s);
        logic inh, acc, can, e_n, e_i;
        inh = (s.op inside {8'hF3, 8'hFB, 8'hCB, 8'hED, 8'hDD, 8'hFD});
        acc = s.insn_end && !inh;
        can = (m_st == 0) || (m_st == 1);
        e_n = acc && can && m_pend;
        e_i = acc && can && !m_pend && s.irq && m_iff1;
        if (s.done && (m_st == 2 || m_st == 3)) m_st = 0;
        else if (e_n)                           m_st = 3;
        else if (e_i)                           m_st = 2;
        else if (s.halt_cmd && m_st == 0)       m_st = 1;
        m_pend  = (m_pend && !e_n) || (s.nmi && !m_nmi_q);
        m_nmi_q = s.nmi;
        if (e_n) m_iff1 = 1'b0;
        else if (e_i) begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
        else if (s.di_ei) begin m_iff1 = s.op[3]; m_iff2 = s.op[3]; end
        else if (s.retn) m_iff1 = m_iff2;
        if (s.im) m_im = s.op[4:3];
    endtask

    // Driver: apply stimulus, push the expected outputs, advance the model.
    task automatic drive(stim_t s, string req);
        item_t it;
        @(negedge clk);
        s_cur = s;
        #1;
        it.req = req;
        it.exp = expect_vec(s);
        sb.push_back(it);
        model_step(s);
    endtask

    // Monitor: compare queued expectations with the outputs mid-cycle.
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            logic [16:0] act;
            it  = sb.pop_front();
            act = observe();
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: outputs actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t s;
        s_cur = nop();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_iff1 = 0; m_iff2 = 0; m_pend = 0; m_nmi_q = 0; m_im = 2'b00;

        drive(nop(), "R12");                       // reset state
        s = nop(); s.ld = 1; s.seqpt = 1; drive(s, "R12");

        // EI, then mode 2
        s = nop(); s.di_ei = 1; s.op = 8'hFB; drive(s, "R6");
        drive(nop(), "R6");
        s = nop(); s.im = 1; s.op = 8'h5E; drive(s, "R7");
        drive(nop(), "R7");

        // inhibited boundary, then accepted mode 2 interrupt
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'hFB; drive(s, "R10");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'hDD; drive(s, "R10");
        s = nop(); s.irq = 1; drive(s, "R10");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'h00; drive(s, "R11");
        s = nop(); s.ld = 1; drive(s, "R2");
        s = nop(); s.vec = 1; drive(s, "R9");
        s = nop(); s.seqpt = 1; drive(s, "R8");
        drive(nop(), "R5");
        drive(nop(), "R3");
        s = nop(); s.done = 1; drive(s, "R12");
        drive(nop(), "R12");

        // mode 1 interrupt
        s = nop(); s.di_ei = 1; s.op = 8'hFB; drive(s, "R6");
        s = nop(); s.im = 1; s.op = 8'h56; drive(s, "R7");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'h3C; drive(s, "R11");
        s = nop(); s.ld = 1; drive(s, "R2");
        s = nop(); s.vec = 1; drive(s, "R2");
        s = nop(); s.seqpt = 1; drive(s, "R8");
        s = nop(); s.done = 1; drive(s, "R12");

        // halt, then maskable blocked by cleared IFF1
        s = nop(); s.halt_cmd = 1; drive(s, "R1");
        s = nop(); s.ld = 1; drive(s, "R1");
        drive(nop(), "R3");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'h00; drive(s, "R11");
        s = nop(); s.ld = 1; drive(s, "R11");

        // NMI beats maskable request
        s = nop(); s.di_ei = 1; s.op = 8'hFB; drive(s, "R6");
        s = nop(); s.nmi = 1; s.irq = 1; drive(s, "R11");
        s = nop(); s.irq = 1; drive(s, "R11");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'h00; drive(s, "R11");
        s = nop(); s.vec = 1; drive(s, "R4");
        s = nop(); s.ld = 1; drive(s, "R4");
        drive(nop(), "R5");
        s = nop(); s.seqpt = 1; drive(s, "R9");
        s = nop(); s.done = 1; drive(s, "R12");
        s = nop(); s.retn = 1; drive(s, "R6");
        drive(nop(), "R6");

        // mode 0: no forcing
        s = nop(); s.im = 1; s.op = 8'h46; drive(s, "R7");
        s = nop(); s.irq = 1; s.insn_end = 1; s.op = 8'h00; drive(s, "R11");
        s = nop(); s.ld = 1; drive(s, "R2");
        s = nop(); s.vec = 1; s.seqpt = 1; drive(s, "R2");
        s = nop(); s.done = 1; drive(s, "R12");

        // held NMI gives a single service
        s = nop(); s.nmi = 1; drive(s, "R11");
        s = nop(); s.nmi = 1; s.insn_end = 1; drive(s, "R11");
        s = nop(); s.nmi = 1; s.done = 1; drive(s, "R12");
        s = nop(); s.nmi = 1; s.insn_end = 1; drive(s, "R11");
        s = nop(); s.nmi = 1; drive(s, "R11");
        drive(nop(), "R3");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule